// File: doc/BRIEF.md
# Byte-Stuffed Command Frame Codec

This block converts between a byte stream from a serial receiver/transmitter and the fixed-width parallel messages of a command controller. On the receive side it looks for a start flag (0x12), removes escape bytes (0x7D), and collects payload bytes until a stop flag (0x13) arrives. If the frame carries exactly one message's worth of bytes, the block presents it as a parallel command together with its opcode. On the transmit side it takes one parallel response per valid/ready handshake. It sends the response as a start flag, then the payload with escapes inserted, then a stop flag, with each byte offered under its own valid/ready handshake.

A message is big-endian. The opcode is its first and most significant byte. It is followed by the address bytes and then the data bytes. With the default widths (32-bit address, 8-bit data) a message is 6 bytes. Commands and responses use the same layout. The framing layer adds no acknowledgement and no error detection.

Receive machine states: `RX_HUNT` (wait for a start flag), `RX_BODY` (collect payload) and `RX_LITERAL` (the next byte is data). Its transitions are:
- `RX_HUNT`→`RX_BODY` on a start flag.
- `RX_BODY`→`RX_BODY` on a start flag, which clears the count, or on a payload byte.
- `RX_BODY`→`RX_LITERAL` on an escape.
- `RX_LITERAL`→`RX_BODY` on any byte.
- `RX_BODY`→`RX_HUNT` on a stop flag, which emits the message only if the count is exact.

Transmit machine states: `TX_IDLE`, `TX_START`, `TX_PAYLOAD`, `TX_LITERAL` and `TX_STOP`. Its transitions are:
- `TX_IDLE`→`TX_START` when a response is accepted.
- `TX_START`→`TX_PAYLOAD` when the start flag is taken.
- `TX_PAYLOAD`→`TX_LITERAL` when an escape is taken in front of a control-valued byte.
- `TX_PAYLOAD` or `TX_LITERAL` →`TX_PAYLOAD` when a data byte is taken and more remain.
- `TX_PAYLOAD` or `TX_LITERAL` →`TX_STOP` when the last data byte is taken.
- `TX_STOP`→`TX_IDLE` when the stop flag is taken.

Top module: `frame_codec`

## Requirements
- R1: After reset, `cmd_valid` and `tx_byte_valid` are low and `rsp_ready` is high.
- R2: Received bytes outside a frame are ignored. A frame opens on 0x12 and closes on 0x13.
- R3: A received 0x7D is dropped, and the byte after it is stored as data unchanged, even when it equals 0x12, 0x13 or 0x7D.
- R4: The first payload byte lands in `cmd_msg[MSG_W-1:MSG_W-8]`, and later bytes follow in descending order. `cmd_opcode` equals the first byte. `cmd_valid` is high for exactly one cycle, the cycle after the clock edge that takes the stop flag.
- R5: A 0x12 received inside a frame discards the bytes collected so far and starts a new message.
- R6: A frame whose unstuffed length is not MSG_BYTES, whether shorter or longer, produces no `cmd_valid`.
- R7: A response is sent as 0x12, then its payload bytes most significant first, then 0x13.
- R8: A payload byte equal to 0x12, 0x13 or 0x7D is sent preceded by an extra 0x7D.
- R9: `rsp_ready` is high only while no frame is being sent. A byte offered with `tx_byte_ready` low stays offered and unchanged until it is taken.
- R10: `cmd_msg` keeps the last accepted message until the next one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle strobe: a complete command is present |
| cmd_msg | output | MSG_W | Last accepted command message |
| cmd_opcode | output | 8 | Opcode byte of `cmd_msg` |
| rsp_valid | input | 1 | A response message is offered |
| rsp_ready | output | 1 | The transmitter can accept a response |
| rsp_msg | input | MSG_W | Response message |
| tx_byte_valid | output | 1 | An outgoing byte is offered |
| tx_byte_ready | input | 1 | The serial transmitter takes the offered byte |
| tx_byte | output | 8 | Outgoing byte |

## Verification
The hardest cases to reach are the ones where a control value must travel as data. In those cases the same byte value has to be treated as a flag in one state and as payload in the other. The receive stimulus sends frames in which an escaped 0x12, 0x13 and 0x7D sit next to real flags. It also interrupts a partial frame with a fresh start flag and sends frames one byte short and one byte long. The transmit stimulus sends a response packed with control values while `tx_byte_ready` is throttled. This holds bytes in both the escape state and the literal state across stalls.

// File: rtl/frame_codec_pkg.sv
package frame_codec_pkg;
    localparam logic [7:0] FLAG_START = 8'h12;
    localparam logic [7:0] FLAG_STOP  = 8'h13;
    localparam logic [7:0] FLAG_ESC   = 8'h7D;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_BODY,
        RX_LITERAL
    } rx_state_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_PAYLOAD,
        TX_LITERAL,
        TX_STOP
    } tx_state_t;

    function automatic logic is_control(input logic [7:0] b);
        return (b == FLAG_START) || (b == FLAG_STOP) || (b == FLAG_ESC);
    endfunction
endpackage

// File: rtl/frame_deframer.sv
module frame_deframer
    import frame_codec_pkg::*;
#(
    parameter int MSG_BYTES = 6,
    localparam int MSG_W = MSG_BYTES * 8,
    localparam int CNT_W = $clog2(MSG_BYTES + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_msg
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MSG_BYTES);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(MSG_BYTES + 1);

    rx_state_t        state, state_nxt;
    logic [CNT_W-1:0] count;
    logic [MSG_W-1:0] shreg;
    logic             take, clear, done;

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_HUNT;
            count     <= '0;
            shreg     <= '0;
            out_valid <= 1'b0;
            out_msg   <= '0;
        end else begin
            state     <= state_nxt;
            out_valid <= done;
            if (done) begin
                out_msg <= shreg;
            end
            if (clear) begin
                count <= '0;
            end else if (take && count != CNT_OVER) begin
                count <= count + 1'b1;
            end
            if (take) begin
                shreg <= {shreg[MSG_W-9:0], in_byte};
            end
        end
    end

    // Next state and control strobes
    always_comb begin
        state_nxt = state;
        take      = 1'b0;
        clear     = 1'b0;
        done      = 1'b0;
        if (in_valid) begin
            unique case (state)
                RX_HUNT: begin
                    if (in_byte == FLAG_START) begin
                        state_nxt = RX_BODY;
                        clear     = 1'b1;
                    end
                end
                RX_BODY: begin
                    if (in_byte == FLAG_START) begin
                        clear = 1'b1;
                    end else if (in_byte == FLAG_STOP) begin
                        state_nxt = RX_HUNT;
                        done      = (count == CNT_FULL);
                    end else if (in_byte == FLAG_ESC) begin
                        state_nxt = RX_LITERAL;
                    end else begin
                        take = 1'b1;
                    end
                end
                RX_LITERAL: begin
                    take      = 1'b1;
                    state_nxt = RX_BODY;
                end
                default: state_nxt = RX_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/frame_framer.sv
module frame_framer
    import frame_codec_pkg::*;
#(
    parameter int MSG_BYTES = 6,
    localparam int MSG_W = MSG_BYTES * 8,
    localparam int IDX_W = $clog2(MSG_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    output logic             msg_ready,
    input  logic [MSG_W-1:0] msg,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MSG_BYTES - 1);

    tx_state_t        state, state_nxt;
    logic [MSG_W-1:0] shreg;
    logic [IDX_W-1:0] idx;
    logic             load, advance;
    logic [7:0]       cur;
    logic             last;

    assign cur  = shreg[MSG_W-1 -: 8];
    assign last = (idx == IDX_LAST);

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            shreg <= '0;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            if (load) begin
                shreg <= msg;
                idx   <= '0;
            end else if (advance) begin
                shreg <= {shreg[MSG_W-9:0], 8'h00};
                idx   <= idx + 1'b1;
            end
        end
    end

    // Outputs and next state
    always_comb begin
        state_nxt = state;
        msg_ready = 1'b0;
        out_valid = 1'b0;
        out_byte  = 8'h00;
        load      = 1'b0;
        advance   = 1'b0;
        unique case (state)
            TX_IDLE: begin
                msg_ready = 1'b1;
                if (msg_valid) begin
                    load      = 1'b1;
                    state_nxt = TX_START;
                end
            end
            TX_START: begin
                out_valid = 1'b1;
                out_byte  = FLAG_START;
                if (out_ready) state_nxt = TX_PAYLOAD;
            end
            TX_PAYLOAD: begin
                out_valid = 1'b1;
                if (is_control(cur)) begin
                    out_byte = FLAG_ESC;
                    if (out_ready) state_nxt = TX_LITERAL;
                end else begin
                    out_byte = cur;
                    if (out_ready) begin
                        advance   = 1'b1;
                        state_nxt = last ? TX_STOP : TX_PAYLOAD;
                    end
                end
            end
            TX_LITERAL: begin
                out_valid = 1'b1;
                out_byte  = cur;
                if (out_ready) begin
                    advance   = 1'b1;
                    state_nxt = last ? TX_STOP : TX_PAYLOAD;
                end
            end
            TX_STOP: begin
                out_valid = 1'b1;
                out_byte  = FLAG_STOP;
                if (out_ready) state_nxt = TX_IDLE;
            end
            default: state_nxt = TX_IDLE;
        endcase
    end
endmodule

// File: rtl/frame_codec.sv
module frame_codec
    import frame_codec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    localparam int MSG_BYTES = 1 + ADDR_W / 8 + DATA_W / 8,
    localparam int MSG_W = MSG_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_byte_valid,
    input  logic [7:0]       rx_byte,
    output logic             cmd_valid,
    output logic [MSG_W-1:0] cmd_msg,
    output logic [7:0]       cmd_opcode,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [MSG_W-1:0] rsp_msg,
    output logic             tx_byte_valid,
    input  logic             tx_byte_ready,
    output logic [7:0]       tx_byte
);
    frame_deframer #(.MSG_BYTES(MSG_BYTES)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_byte_valid),
        .in_byte   (rx_byte),
        .out_valid (cmd_valid),
        .out_msg   (cmd_msg)
    );

    assign cmd_opcode = cmd_msg[MSG_W-1 -: 8];

    frame_framer #(.MSG_BYTES(MSG_BYTES)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (rsp_valid),
        .msg_ready (rsp_ready),
        .msg       (rsp_msg),
        .out_valid (tx_byte_valid),
        .out_ready (tx_byte_ready),
        .out_byte  (tx_byte)
    );
endmodule

// File: rtl/frame_codec_chk.sv
module frame_codec_chk
    import frame_codec_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_byte_valid,
    input logic [7:0] rx_byte,
    input logic       cmd_valid,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic       tx_byte_valid,
    input logic       tx_byte_ready,
    input logic [7:0] tx_byte
);
    p_cmd_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(rx_byte_valid) && $past(rx_byte) == FLAG_STOP));

    p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_byte_valid && !tx_byte_ready) |=> (tx_byte_valid && $stable(tx_byte)));

    p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ready && tx_byte_valid));

    p_start_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (tx_byte_valid && tx_byte == FLAG_START));
endmodule

bind frame_codec frame_codec_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_byte_valid (rx_byte_valid),
    .rx_byte       (rx_byte),
    .cmd_valid     (cmd_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .tx_byte_valid (tx_byte_valid),
    .tx_byte_ready (tx_byte_ready),
    .tx_byte       (tx_byte)
);

// File: tb/frame_codec_tb.sv
module frame_codec_tb;
    localparam int MW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_byte_valid = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          cmd_valid;
    logic [MW-1:0] cmd_msg;
    logic [7:0]    cmd_opcode;
    logic          rsp_valid = 1'b0;
    logic          rsp_ready;
    logic [MW-1:0] rsp_msg = '0;
    logic          tx_byte_valid;
    logic          tx_byte_ready = 1'b0;
    logic [7:0]    tx_byte;

    int tests = 0;
    int fails = 0;
    int n_cmd = 0;
    logic [MW-1:0] cap_msg = '0;
    logic [7:0]    cap_op = '0;

    always #4 clk = ~clk;

    frame_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
        .cmd_valid(cmd_valid), .cmd_msg(cmd_msg), .cmd_opcode(cmd_opcode),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_msg(rsp_msg),
        .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tx_byte_ready), .tx_byte(tx_byte)
    );

    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            n_cmd++;
            cap_msg = cmd_msg;
            cap_op  = cmd_opcode;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte_valid = 1'b1;
        rx_byte = b;
        @(negedge clk);
        rx_byte_valid = 1'b0;
    endtask

    task automatic send_payload(input logic [MW-1:0] m);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = m[MW-1-8*i -: 8];
            if (b == 8'h12 || b == 8'h13 || b == 8'h7D) send(8'h7D);
            send(b);
        end
    endtask

    task automatic t_reset;
        chk("R1 cmd_valid", 64'(cmd_valid), 64'd0);
        chk("R1 tx_byte_valid", 64'(tx_byte_valid), 64'd0);
        chk("R1 rsp_ready", 64'(rsp_ready), 64'd1);
    endtask

    task automatic t_basic;
        int n0;
        n0 = n_cmd;
        send(8'h55); send(8'h13); send(8'h7D);
        send(8'h12);
        send_payload(48'hA1B2C3D4E5F6);
        send(8'h13);
        @(negedge clk);
        chk("R2 one frame after noise", 64'(n_cmd - n0), 64'd1);
        chk("R4 message order", 64'(cap_msg), 64'hA1B2C3D4E5F6);
        chk("R4 opcode", 64'(cap_op), 64'hA1);
        chk("R4 pulse ended", 64'(cmd_valid), 64'd0);
    endtask

    task automatic t_escaped;
        int n0;
        n0 = n_cmd;
        send(8'h12);
        send_payload(48'h127D13B27D44);
        send(8'h13);
        @(negedge clk);
        chk("R3 escaped frame accepted", 64'(n_cmd - n0), 64'd1);
        chk("R3 literal control bytes", 64'(cap_msg), 64'h127D13B27D44);
    endtask

    task automatic t_restart;
        int n0;
        n0 = n_cmd;
        send(8'h12); send(8'h11); send(8'h22); send(8'h33);
        send(8'h12);
        send_payload(48'h0102030405AA);
        send(8'h13);
        @(negedge clk);
        chk("R5 restart count", 64'(n_cmd - n0), 64'd1);
        chk("R5 restart content", 64'(cap_msg), 64'h0102030405AA);
    endtask

    task automatic t_badlen;
        int n0;
        n0 = n_cmd;
        send(8'h12);
        for (int i = 0; i < 5; i++) send(8'h40 + 8'(i));
        send(8'h13);
        send(8'h12);
        for (int i = 0; i < 7; i++) send(8'h60 + 8'(i));
        send(8'h13);
        @(negedge clk);
        chk("R6 short and long dropped", 64'(n_cmd - n0), 64'd0);
        chk("R10 cmd_msg held", 64'(cmd_msg), 64'h0102030405AA);
    endtask

    task automatic t_tx(input string tag, input logic [MW-1:0] m, input int stall_mod);
        logic [7:0] exp_q[$];
        logic [7:0] got_q[$];
        logic [7:0] prev;
        bit prev_stalled;
        bit stable_ok;
        bit seq_ok;
        int cyc;
        exp_q.push_back(8'h12);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = m[MW-1-8*i -: 8];
            if (b == 8'h12 || b == 8'h13 || b == 8'h7D) exp_q.push_back(8'h7D);
            exp_q.push_back(b);
        end
        exp_q.push_back(8'h13);
        chk({tag, " R9 ready when idle"}, 64'(rsp_ready), 64'd1);
        rsp_msg = m;
        rsp_valid = 1'b1;
        prev = 8'h00;
        prev_stalled = 0;
        stable_ok = 1;
        cyc = 0;
        while (got_q.size() < exp_q.size() && cyc < 400) begin
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            tx_byte_ready = (stall_mod == 0) || (cyc % stall_mod == 0);
            if (prev_stalled && (!tx_byte_valid || tx_byte != prev)) stable_ok = 0;
            if (tx_byte_valid && tx_byte_ready) got_q.push_back(tx_byte);
            prev_stalled = tx_byte_valid && !tx_byte_ready;
            prev = tx_byte;
        end
        @(negedge clk);
        tx_byte_ready = 1'b0;
        seq_ok = (got_q.size() == exp_q.size());
        if (seq_ok) begin
            for (int i = 0; i < exp_q.size(); i++) if (got_q[i] != exp_q[i]) seq_ok = 0;
        end
        chk({tag, " R7 R8 byte sequence"}, 64'(seq_ok), 64'd1);
        chk({tag, " byte count"}, 64'(got_q.size()), 64'(exp_q.size()));
        chk({tag, " R9 held while stalled"}, 64'(stable_ok), 64'd1);
        chk({tag, " R9 idle after frame"}, 64'({rsp_ready, tx_byte_valid}), 64'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_escaped();
        t_restart();
        t_badlen();
        t_tx("plain", 48'h0A1B2C3D4E5F, 0);
        t_tx("stuffed", 48'h7D1213A012FF, 3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule